// File: doc/BRIEF.md
# Receive error status reporting unit

This block forms the three visible receive error bits of a serial receiver: received break, framing error and parity error. It sits beside a character FIFO whose entries each carry their own three flags. It does not hold the FIFO. It sees two things from it: the flags of each character as it is written, and the flags of the entry at the head, together with a valid indication and a read strobe.

Two reporting modes are offered. In per-character mode the output shows the flags of the head entry, which is the next character to be read. In block mode each output bit is a sticky OR of that flag over every character seen since the last clear. A sub-mode select decides where block mode collects its flags: at the write side as characters enter, or at the read side as head entries are consumed. Three things clear the sticky state: a clear-error command, a receiver reset, or the global reset. A change of either mode select also clears it.

Top module: `rx_err_status`

## Requirements
- R1: With `blk_mode`=0 and `top_valid`=1, `status` equals `top_flags` in the same cycle. Bit 2 is received break, bit 1 is framing error and bit 0 is parity error, on every flag bus.
- R2: With `blk_mode`=0 and `top_valid`=0, `status` is 3'b000.
- R3: With `blk_mode`=1 and `acc_on_read`=0, a cycle with `wr_stb`=1 ORs `wr_flags` into the status shown after the next clock edge. In this sub-mode a read strobe has no effect.
- R4: With `blk_mode`=1 and `acc_on_read`=1, a cycle with `rd_stb`=1 and `top_valid`=1 ORs `top_flags` into the status shown after the next clock edge. In this sub-mode `wr_stb` has no effect, and neither does `rd_stb` while `top_valid`=0.
- R5: In block mode, a status bit that is set stays set as long as no clear, receiver reset, mode change or global reset occurs.
- R6: A cycle with `clr_err`=1 or `rx_rst`=1 and no new flags leaves the block-mode status at 3'b000 after the clock edge.
- R7: When a clear and a new flag contribution fall in the same cycle, the status after the edge equals exactly the new flags.
- R8: A change of `blk_mode` or `acc_on_read` between cycles clears the sticky state. Flags accepted in that same cycle under the new setting are kept.
- R9: While `rst_n`=0 the sticky state is zero, so the block-mode status reads 3'b000 without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| blk_mode | input | 1 | 0: per-character reporting, 1: sticky block reporting |
| acc_on_read | input | 1 | Block collection point: 0 at write, 1 at read |
| wr_stb | input | 1 | A character is being written into the FIFO |
| wr_flags | input | 3 | Flags of the character being written {break, framing, parity} |
| top_valid | input | 1 | The FIFO head holds a character |
| top_flags | input | 3 | Flags of the head character {break, framing, parity} |
| rd_stb | input | 1 | The head character is being read |
| clr_err | input | 1 | Clear-error command |
| rx_rst | input | 1 | Receiver reset command |
| status | output | 3 | Reported {break, framing, parity} |

## Verification
The assertions take for granted that `top_flags` is meaningful only while `top_valid` is high. They also assume that a read strobe without a valid head entry is not a consumed character. The bench respects this: it always presents a defined `top_flags` value and raises `rd_stb` without `top_valid` only to show that such a strobe is ignored. Mode selects and commands change only at the falling clock edge. The bench holds each mode setting for several cycles, except where a change in the same cycle as a flag contribution is the point of the test.

// File: rtl/rx_err_status.sv
module rx_err_status #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_mode,
  input  logic          acc_on_read,
  input  logic          wr_stb,
  input  logic [FW-1:0] wr_flags,
  input  logic          top_valid,
  input  logic [FW-1:0] top_flags,
  input  logic          rd_stb,
  input  logic          clr_err,
  input  logic          rx_rst,
  output logic [FW-1:0] status
);

  logic [FW-1:0] acc_q;
  logic [1:0]    mode_q;
  logic          mode_chg;
  logic          wipe;
  logic          wr_take;
  logic          rd_take;
  logic [FW-1:0] fresh;

  assign mode_chg = {blk_mode, acc_on_read} != mode_q;
  assign wipe     = clr_err | rx_rst | mode_chg;
  assign wr_take  = !acc_on_read && wr_stb;
  assign rd_take  = acc_on_read && rd_stb && top_valid;
  assign fresh    = (wr_take ? wr_flags : '0) | (rd_take ? top_flags : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mode_q <= 2'b00;
    end else begin
      acc_q  <= (wipe ? '0 : acc_q) | fresh;
      mode_q <= {blk_mode, acc_on_read};
    end
  end

  assign status = blk_mode ? acc_q : (top_valid ? top_flags : '0);

  p_char_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && !top_valid) |-> (status == '0));

  p_wr_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_on_read && wr_stb) |=> ((acc_q & $past(wr_flags)) == $past(wr_flags)));

  p_rd_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_on_read && rd_stb && top_valid) |=> ((acc_q & $past(top_flags)) == $past(top_flags)));

  p_rd_side_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_on_read && !(rd_stb && top_valid) && !clr_err && !rx_rst && !mode_chg) |=> $stable(acc_q));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_err && !rx_rst && !mode_chg) |=> ((acc_q & $past(acc_q)) == $past(acc_q)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_err || rx_rst) && !(!acc_on_read && wr_stb) && !(acc_on_read && rd_stb && top_valid))
      |=> (acc_q == '0));

  p_mode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !wr_stb && !rd_stb) |=> (acc_q == '0));

endmodule

// File: tb/tb_rx_err_status.sv
module tb_rx_err_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blk_mode = 1'b0, acc_on_read = 1'b0;
  logic       wr_stb = 1'b0, top_valid = 1'b0, rd_stb = 1'b0;
  logic       clr_err = 1'b0, rx_rst = 1'b0;
  logic [2:0] wr_flags = '0, top_flags = '0;
  logic [2:0] status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_err_status dut (
    .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .acc_on_read(acc_on_read),
    .wr_stb(wr_stb), .wr_flags(wr_flags), .top_valid(top_valid),
    .top_flags(top_flags), .rd_stb(rd_stb), .clr_err(clr_err),
    .rx_rst(rx_rst), .status(status)
  );

  // fields: blk aor wr wflags tv tflags rd clr rxr expected
  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_0_0_000_1_101_0_0_0_101, // R1
    16'b0_0_0_000_0_111_0_0_0_000, // R2
    16'b0_0_0_000_1_010_1_0_0_010, // R1
    16'b1_0_0_000_0_000_0_0_0_000, // R8
    16'b1_0_1_001_0_000_0_0_0_001, // R3
    16'b1_0_1_100_0_000_0_0_0_101, // R3
    16'b1_0_0_000_1_010_1_0_0_101, // R3 read ignored
    16'b1_0_0_000_0_000_0_0_0_101, // R5
    16'b1_0_0_000_0_000_0_1_0_000, // R6
    16'b1_0_1_010_0_000_0_1_0_010, // R7
    16'b1_0_0_000_0_000_0_0_1_000, // R6
    16'b1_1_1_111_0_000_0_0_0_000, // R4 write ignored, R8
    16'b1_1_0_000_1_100_1_0_0_100, // R4
    16'b1_1_0_000_0_011_1_0_0_100, // R4 no valid
    16'b1_1_0_000_1_001_1_0_0_101, // R4
    16'b1_1_0_000_1_010_0_0_0_101, // R5
    16'b1_1_0_000_1_010_1_0_1_010, // R7
    16'b1_0_1_001_0_000_0_0_0_001, // R8
    16'b0_0_0_000_1_011_0_0_0_011, // R1
    16'b1_0_0_000_0_000_0_0_0_000  // R8
  };
  localparam int VREQ [NV] = '{1,2,1,8,3,3,3,5,6,7,6,4,4,4,4,5,7,8,1,8};

  task automatic check(input int req, input logic [2:0] exp, input string what);
    checks++;
    if (status !== exp) begin
      failures++;
      $display("FAIL R%0d %s: status=%b expected=%b", req, what, status, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    blk_mode = 1'b1;
    #1;
    check(9, 3'b000, "status during reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(9, 3'b000, "status after reset release");
    @(negedge clk);
    blk_mode = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {blk_mode, acc_on_read, wr_stb, wr_flags, top_valid, top_flags,
       rd_stb, clr_err, rx_rst} = VEC[i][15:3];
      @(posedge clk); #1;
      check(VREQ[i], VEC[i][2:0], $sformatf("table vector %0d", i));
    end

    @(negedge clk);
    {wr_stb, rd_stb, clr_err, rx_rst} = '0;
    blk_mode = 1'b0; top_valid = 1'b1;
    for (int f = 0; f < 8; f++) begin
      top_flags = 3'(f);
      #1;
      check(1, 3'(f), "head flags shown directly");
    end
    top_valid = 1'b0;
    #1;
    check(2, 3'b000, "empty head in per-character mode");

    // R9: global reset clears sticky state without a clock
    @(negedge clk);
    blk_mode = 1'b1; acc_on_read = 1'b0;
    @(negedge clk);
    wr_stb = 1'b1; wr_flags = 3'b110;
    @(negedge clk);
    wr_stb = 1'b0;
    check(3, 3'b110, "write collection before reset");
    #1 rst_n = 1'b0;
    #1;
    check(9, 3'b000, "asynchronous reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(9, 3'b000, "after second reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule